// File: doc/BRIEF.md
# Quadrature Encoder Emulator for a Tracking Angle Counter

This block turns single-step angle updates into incremental encoder signals. A tracking loop upstream issues a step strobe with a direction bit whenever the measured angle moves by one least significant bit. The block keeps its own natural-binary angle count at a selectable resolution of 10, 12, 14 or 16 bits. It derives two quadrature phases from the two lowest count bits, so a downstream incremental-encoder receiver can follow the angle.

A shared status output has two uses, picked by a mode pin. In index mode it flags the zero angle, which gives the receiver a once-per-turn reference. In busy mode it carries a fixed-width pulse that starts with every count update, so the receiver can avoid reading the angle while it changes. The encoder phases are enabled by an active-low pin. The falling edge of that pin samples the resolution select, and changes to the select at any other time are ignored.

Top module: `quad_encoder_emulator`

## Requirements
- R1: The latched resolution select picks the count width: 2'b00 gives 10 bits, 2'b01 gives 12, 2'b10 gives 14 and 2'b11 gives 16. The count wraps modulo 2 to the power of that width in both directions.
- R2: The resolution select is sampled only at a clock edge where `emu_en_n` is low and was high at the previous edge. At any other time a new value on `res_sel` has no effect on the wrap point.
- R3: On each clock edge with `step_valid` high, the count goes up by one when `step_up` is 1 and down by one when `step_up` is 0. Without `step_valid` the count holds.
- R4: The phases are registered from the count one edge after the count changes, with `enc_a` = bit1 XOR bit0 and `enc_b` = bit1. Counting up therefore gives (A,B) = 00, 10, 11, 01, so A leads B. Counting down gives the reverse order.
- R5: While `emu_en_n` is high, `enc_a` and `enc_b` are 0 from the next edge on, and the count keeps following steps. The phases show the current count at the first edge after `emu_en_n` returns low.
- R6: With `idx_mode` = 0, `idx_busy` is 1 exactly when every bit of the count at the latched width is 0, registered one edge after the count.
- R7: With `idx_mode` = 1, `idx_busy` goes high one edge after a step and stays high for BUSY_CYCLES cycles (50 at the default 100 MHz clock, which is 0.5 µs). A new step during the pulse restarts the full width.
- R8: A synchronous active-low reset clears the count to 0, sets the latched resolution to 16 bits and drives `enc_a`, `enc_b` and `idx_busy` to 0.
- R9: A step on the same edge as the resolution latch wraps at the previously latched width. The new width applies from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Design clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_valid | input | 1 | One-LSB angle update strobe, one step per cycle |
| step_up | input | 1 | Step direction: 1 increments, 0 decrements |
| res_sel | input | 2 | Resolution select, sampled on the enable falling edge |
| emu_en_n | input | 1 | Encoder phase enable, active low |
| idx_mode | input | 1 | 0: zero-index flag, 1: update busy pulse |
| enc_a | output | 1 | Quadrature phase A |
| enc_b | output | 1 | Quadrature phase B |
| idx_busy | output | 1 | Zero index or busy pulse, chosen by `idx_mode` |

## Verification
Two functions can meet on the same edge: the resolution latch on the enable falling edge, and a count step whose wrap point depends on that latch. The bench first latches the 10-bit width. It then lowers `emu_en_n` with the select at 16 bits while it issues a down step from zero on that same edge, and follows with one up step. A design that wraps the coinciding step at the old width reaches 1024 and keeps the index low. One that applies the new width at once reaches zero and raises it. The restarted busy pulse is a second overlap: it is timed against a step issued while an earlier pulse is still running.

// File: rtl/qenc_pkg.sv
// Package: shared types and helpers for the quadrature encoder emulator.
// Assumes the widest resolution is 16 bits and that widths rise by two bits
// per select code, starting at 10 bits.
package qenc_pkg;

    localparam int ANGLE_W       = 16;
    localparam int MIN_RES_BITS  = 10;
    localparam int RES_STEP_BITS = 2;

    typedef enum logic [1:0] {
        RES_10B = 2'b00,
        RES_12B = 2'b01,
        RES_14B = 2'b10,
        RES_16B = 2'b11
    } res_e;

    // Mask that keeps the active bits of the count at a given resolution.
    function automatic logic [ANGLE_W-1:0] res_mask(input res_e r);
        logic [ANGLE_W:0] top_bit;
        top_bit = (ANGLE_W+1)'(1) << (MIN_RES_BITS + RES_STEP_BITS * int'(r));
        return ANGLE_W'(top_bit - (ANGLE_W+1)'(1));
    endfunction

endpackage

// File: rtl/qenc_res_latch.sv
// Module: resolution latch.
// Samples the resolution select on the falling edge of the active-low
// emulation enable and holds it otherwise. The enable is assumed to be
// synchronous to clk. The edge history clears to 0 in reset, so an enable
// that is held low through reset does not count as a falling edge.
module qenc_res_latch
    import qenc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic emu_en_n,
    input  res_e res_sel,
    output res_e res_q
);

    logic en_prev_q;
    logic en_fall;

    // Falling edge of the enable: high last edge, low now.
    assign en_fall = en_prev_q & ~emu_en_n;

    // Keep last enable level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) en_prev_q <= 1'b0;
        else        en_prev_q <= emu_en_n;
    end

    // Capture the select on the enable falling edge; default to 16 bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       res_q <= RES_16B;
        else if (en_fall) res_q <= res_sel;
    end

    // R2: with the enable high at an edge, no capture can happen there.
    p_res_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        emu_en_n |=> $stable(res_q));

    // R2: two consecutive low samples mean no edge, so the width holds.
    p_res_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!emu_en_n && !en_prev_q) |=> $stable(res_q));

endmodule

// File: rtl/qenc_angle_counter.sv
// Module: angle counter.
// Keeps a natural-binary count of ANGLE_W bits and moves it one LSB per
// step strobe, wrapping at the active resolution given by 'mask'. The
// stored value is always read through the mask, so any stale upper bits
// after the width shrinks are never seen by the rest of the block.
module qenc_angle_counter
    import qenc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_valid,
    input  logic               step_up,
    input  logic [ANGLE_W-1:0] mask,
    output logic [ANGLE_W-1:0] eff_count
);

    logic [ANGLE_W-1:0] count_q;
    logic [ANGLE_W-1:0] count_inc;
    logic [ANGLE_W-1:0] count_dec;

    // Count as seen at the current width.
    assign eff_count = count_q & mask;

    // Neighbour values, wrapped at the current width.
    always_comb begin
        count_inc = (eff_count + ANGLE_W'(1)) & mask;
        count_dec = (eff_count - ANGLE_W'(1)) & mask;
    end

    // Step the count by one in the strobed direction.
    always_ff @(posedge clk) begin
        if (!rst_n)          count_q <= '0;
        else if (step_valid) count_q <= step_up ? count_inc : count_dec;
    end

    // R3: no strobe, no movement.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !step_valid |=> $stable(count_q));

    // R3: a strobe always changes the stored count.
    p_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid |=> (count_q != $past(count_q)));

    // R1: a stepped value never carries bits above the width in force.
    p_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid |=> ((count_q & ~$past(mask)) == '0));

endmodule

// File: rtl/qenc_phase_out.sv
// Module: quadrature phase driver.
// Registers phases A and B from the two low count bits, A = b1^b0 and
// B = b1, so that up-counting gives A leading B. Both phases are forced
// low while the active-low enable is high. Assumes the count moves by at
// most one per cycle, so that only one phase changes per edge.
module qenc_phase_out (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       emu_en_n,
    input  logic [1:0] low_bits,
    output logic       enc_a,
    output logic       enc_b
);

    logic a_next;
    logic b_next;

    // Two-bit Gray mapping of the count, gated by the enable.
    always_comb begin
        a_next = ~emu_en_n & (low_bits[1] ^ low_bits[0]);
        b_next = ~emu_en_n & low_bits[1];
    end

    // Output registers, so the phases do not glitch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enc_a <= 1'b0;
            enc_b <= 1'b0;
        end else begin
            enc_a <= a_next;
            enc_b <= b_next;
        end
    end

    // R5: disabled emulation drives both phases low.
    p_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        emu_en_n |=> (!enc_a && !enc_b));

    // R4: while enabled, at most one phase toggles per edge.
    p_gray_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!emu_en_n && !$past(emu_en_n))
        |=> ($countones({enc_a, enc_b} ^ $past({enc_a, enc_b})) <= 1));

endmodule

// File: rtl/qenc_index_busy.sv
// Module: zero-index / busy pulse generator.
// In index mode the output is a registered zero flag of the count. In busy
// mode a timer is loaded on every step and the output stays high while it
// runs, giving a pulse of BUSY_CYCLES cycles that a new step restarts. The
// timer runs in both modes, so a mode switch shows any pulse in progress.
module qenc_index_busy #(
    parameter int BUSY_CYCLES = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_valid,
    input  logic idx_mode,
    input  logic at_zero,
    output logic idx_busy
);

    localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

    logic [BUSY_W-1:0] busy_cnt;
    logic              busy_live;

    assign busy_live = (busy_cnt != '0);

    // Pulse timer: reload on a step, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)          busy_cnt <= '0;
        else if (step_valid) busy_cnt <= BUSY_W'(BUSY_CYCLES);
        else if (busy_live)  busy_cnt <= busy_cnt - BUSY_W'(1);
    end

    // Shared output register, selected by the mode pin.
    always_ff @(posedge clk) begin
        if (!rst_n) idx_busy <= 1'b0;
        else        idx_busy <= idx_mode ? busy_live : at_zero;
    end

    // R7: every step restarts the full pulse width.
    p_busy_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid |=> (busy_cnt == BUSY_W'(BUSY_CYCLES)));

    // R7: a running timer in busy mode shows at the output.
    p_busy_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_mode && busy_live) |=> idx_busy);

    // R6: zero angle in index mode raises the flag.
    p_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!idx_mode && at_zero) |=> idx_busy);

    // R6: any other angle in index mode keeps it low.
    p_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!idx_mode && !at_zero) |=> !idx_busy);

endmodule

// File: rtl/quad_encoder_emulator.sv
// Module: quadrature encoder emulator (top).
// Joins the resolution latch, the angle counter, the phase driver and the
// index/busy generator. All inputs are assumed synchronous to clk. The busy
// pulse width is derived from the clock rate and the wanted pulse length.
module quad_encoder_emulator
    import qenc_pkg::*;
#(
    parameter int CLK_HZ  = 100_000_000,
    parameter int BUSY_NS = 500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_valid,
    input  logic       step_up,
    input  logic [1:0] res_sel,
    input  logic       emu_en_n,
    input  logic       idx_mode,
    output logic       enc_a,
    output logic       enc_b,
    output logic       idx_busy
);

    localparam int BUSY_RAW    = (CLK_HZ / 1_000_000) * BUSY_NS / 1000;
    localparam int BUSY_CYCLES = (BUSY_RAW < 1) ? 1 : BUSY_RAW;

    res_e               res_q;
    logic [ANGLE_W-1:0] cur_mask;
    logic [ANGLE_W-1:0] eff_count;
    logic               at_zero;

    // Width in force and zero detection at that width.
    assign cur_mask = res_mask(res_q);
    assign at_zero  = (eff_count == '0);

    qenc_res_latch u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .emu_en_n (emu_en_n),
        .res_sel  (res_e'(res_sel)),
        .res_q    (res_q)
    );

    qenc_angle_counter u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_valid (step_valid),
        .step_up    (step_up),
        .mask       (cur_mask),
        .eff_count  (eff_count)
    );

    qenc_phase_out u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .emu_en_n (emu_en_n),
        .low_bits (eff_count[1:0]),
        .enc_a    (enc_a),
        .enc_b    (enc_b)
    );

    qenc_index_busy #(
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_idx (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_valid (step_valid),
        .idx_mode   (idx_mode),
        .at_zero    (at_zero),
        .idx_busy   (idx_busy)
    );

    // R1: the active width always covers at least the 10 low bits.
    p_mask_floor_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cur_mask[9:0] == 10'h3FF);

    // R8: after a reset edge, the phases and the shared output are low.
    p_reset_out_r8: assert property (@(posedge clk)
        !rst_n |=> (!enc_a && !enc_b && !idx_busy));

endmodule

// File: tb/quad_encoder_emulator_test.sv
module quad_encoder_emulator_test;

    localparam int CLK_PERIOD = 10;
    localparam int BUSY_LEN   = 50;
    localparam int N_VEC      = 10;

    // Vector: {step_up, exp_a, exp_b, exp_idx}, walked from count 0 at 16 bits.
    localparam logic [3:0] VEC [N_VEC] = '{
        4'b1_10_0,  // ->1
        4'b1_11_0,  // ->2
        4'b1_01_0,  // ->3
        4'b1_00_0,  // ->4
        4'b0_01_0,  // ->3
        4'b0_11_0,  // ->2
        4'b0_10_0,  // ->1
        4'b0_00_1,  // ->0
        4'b0_01_0,  // ->65535
        4'b1_00_1   // ->0
    };

    logic       clk = 1'b0;
    logic       rst_n, step_valid, step_up, emu_en_n, idx_mode;
    logic [1:0] res_sel;
    logic       enc_a, enc_b, idx_busy;
    int         checks = 0;
    int         errors = 0;
    bit         done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    quad_encoder_emulator uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_valid (step_valid),
        .step_up    (step_up),
        .res_sel    (res_sel),
        .emu_en_n   (emu_en_n),
        .idx_mode   (idx_mode),
        .enc_a      (enc_a),
        .enc_b      (enc_b),
        .idx_busy   (idx_busy)
    );

    task automatic chk(input string tag, input logic [2:0] got, input logic [2:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    // One step; returns at the falling edge after outputs have registered it.
    task automatic do_step(input logic up);
        step_valid = 1'b1;
        step_up    = up;
        @(negedge clk);
        step_valid = 1'b0;
        @(negedge clk);
    endtask

    // n back-to-back steps, then one edge for the output stage.
    task automatic run_steps(input int n, input logic up);
        step_valid = 1'b1;
        step_up    = up;
        repeat (n) @(negedge clk);
        step_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; step_valid = 1'b0; step_up = 1'b0;
        emu_en_n = 1'b0; idx_mode = 1'b0; res_sel = 2'b11;
        repeat (3) @(negedge clk);
        chk("R8 phases and output low in reset", {enc_a, enc_b, idx_busy}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8/R6 count zero after reset", {enc_a, enc_b, idx_busy}, 3'b001);

        // Vector walk: R3 stepping, R4 phase order, R6 index, R1 16-bit wrap.
        for (int i = 0; i < N_VEC; i++) begin
            do_step(VEC[i][3]);
            chk($sformatf("R3/R4/R6 vector %0d", i), {enc_a, enc_b, idx_busy}, VEC[i][2:0]);
        end

        // R1: latch 10 bits on a falling edge, then wrap after 1024 ups.
        res_sel  = 2'b00;
        emu_en_n = 1'b1;
        @(negedge clk);
        emu_en_n = 1'b0;
        @(negedge clk);
        run_steps(1023, 1'b1);
        chk("R1 count 1023 at 10 bits", {enc_a, enc_b, idx_busy}, 3'b010);
        do_step(1'b1);
        chk("R1 10-bit wrap to zero", {enc_a, enc_b, idx_busy}, 3'b001);

        // R2: a select change without an enable edge is ignored.
        res_sel = 2'b11;
        repeat (2) @(negedge clk);
        run_steps(1024, 1'b1);
        chk("R2 select ignored, still 10-bit wrap", {enc_a, enc_b, idx_busy}, 3'b001);

        // R9: latch to 16 bits and step down from zero on the same edge.
        emu_en_n = 1'b1;
        @(negedge clk);
        emu_en_n   = 1'b0;
        step_valid = 1'b1;
        step_up    = 1'b0;
        @(negedge clk);
        step_valid = 1'b0;
        @(negedge clk);
        chk("R9 coinciding step wraps at old width (1023)", {enc_a, enc_b, idx_busy}, 3'b010);
        do_step(1'b1);
        chk("R9 new width applies next (1024)", {enc_a, enc_b, idx_busy}, 3'b000);

        // R5: disabled phases stay low while the count tracks.
        emu_en_n = 1'b1;
        repeat (2) @(negedge clk);
        do_step(1'b1);
        chk("R5 phases low while disabled", {enc_a, enc_b}, 3'b000);
        emu_en_n = 1'b0;
        @(negedge clk);
        chk("R5 count tracked while disabled (1025)", {enc_a, enc_b, idx_busy}, 3'b100);

        // R7: busy pulse width and restart.
        idx_mode = 1'b1;
        repeat (BUSY_LEN + 5) @(negedge clk);
        chk("R7 idle without steps", {2'b00, idx_busy}, 3'b000);
        do_step(1'b1);
        chk("R7 pulse starts after step", {2'b00, idx_busy}, 3'b001);
        repeat (BUSY_LEN - 1) @(negedge clk);
        chk("R7 pulse still high at last cycle", {2'b00, idx_busy}, 3'b001);
        @(negedge clk);
        chk("R7 pulse ends after width", {2'b00, idx_busy}, 3'b000);
        do_step(1'b0);
        repeat (30) @(negedge clk);
        do_step(1'b0);
        repeat (BUSY_LEN - 1) @(negedge clk);
        chk("R7 restarted pulse still high", {2'b00, idx_busy}, 3'b001);
        @(negedge clk);
        chk("R7 restarted pulse ends", {2'b00, idx_busy}, 3'b000);

        // R8: reset clears count and returns width to 16 bits.
        idx_mode = 1'b0;
        res_sel  = 2'b00;
        emu_en_n = 1'b1;
        @(negedge clk);
        emu_en_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 reset outputs low", {enc_a, enc_b, idx_busy}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 count cleared", {enc_a, enc_b, idx_busy}, 3'b001);
        run_steps(1024, 1'b1);
        chk("R8 width back to 16 bits (1024 not zero)", {enc_a, enc_b, idx_busy}, 3'b000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule